// File: doc/BRIEF.md
# Platform Interrupt Controller

The block collects level-sensitive interrupt requests from a set of peripheral sources and routes them to a small number of targets, such as processor harts. Each source has a programmable priority. Each target has its own enable mask and its own priority threshold. A target raises its request line while at least one source is pending, enabled for it, and above its threshold.

A handler reads the target's claim/complete register to learn which source to serve. The read returns the winning ID and clears that source's pending bit in the same access. The handler then writes the same ID back to signal completion. While a source is being served, a new request from it is held off. Once completion arrives, the source may become pending again if its input is still high.

Software reaches all state through a simple APB-style port with 32-bit data. Every access completes in one wait-free cycle, and an access to an undefined address inside the window returns an error.

Top module: `pic_top`

## Requirements
- R1: The priority of source ID n is at byte offset 4·n. It holds a 2-bit field in bits [1:0]. Bits [31:2] ignore writes and read 0. The entry for ID 0 always reads 0.
- R2: The pending word is at offset 0x1000. Bit n is the pending flag of source n, and bit 0 always reads 0. A source input that is high sets its pending flag on the next clock edge. The flag then stays set until it is claimed. Writes to this word are ignored and return no error.
- R3: The enable word of target t is at offset 0x2000 + 0x80·t. Bit n enables source n for that target. Bit 0 always reads 0.
- R4: The threshold of target t is at offset 0x200000 + 0x1000·t. It holds a 2-bit field in bits [1:0], and the upper bits read 0.
- R5: A read of the claim/complete register of target t, at offset 0x200004 + 0x1000·t, returns the ID of the source that is pending, enabled for t, and has the highest non-zero priority. On equal priority the lower ID wins. The read returns 0 if no source qualifies. The threshold does not affect the result.
- R6: A claim read that returns a non-zero ID clears that source's pending flag at the end of the access.
- R7: A claimed source is not marked pending again until a valid completion for it is written. If its input is still high, it becomes pending on the edge after the completion.
- R8: Writing ID n to a target's claim/complete register ends service of source n only if n is non-zero, below the source count, and enabled for that target. Any other value is ignored. The written ID is not compared with the last claimed ID.
- R9: irq_o[t] is high exactly when the highest priority among pending sources enabled for target t is greater than that target's threshold.
- R10: An access to any other address in the window returns pslverr_o high in the same cycle as pready_o. A read of such an address returns data 0, and a write to it changes no state.
- R11: After reset, every priority, pending, enable and threshold field is 0, every claim returns 0, and every irq_o bit is low.
- R12: pready_o is high in the access phase of every transfer, so no wait states are inserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_SRC | Level interrupt inputs; bit 0 unused |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | 1 = write, 0 = read |
| paddr_i | input | ADDR_W | Byte address within the window |
| pwdata_i | input | 32 | Write data |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Transfer complete |
| pslverr_o | output | 1 | Error for an undefined address |
| irq_o | output | NUM_TGT | Interrupt request per target |

## Verification
The bench targets several corner cases. Equal-priority ties check that the lower ID wins; a design that compared with greater-or-equal would hand out the higher ID. Claims are made while a target's threshold masks its line; a design that applied the threshold to claims would return 0. A completion is written for an ID the target has not enabled; a design that dropped the enable check would let the source become pending again. Source inputs are held high across claim and completion; a design without the in-service hold would show the pending bit reappear at once after the claim. Unmapped addresses next to real registers check the decode edges, and writes of all ones check that reserved bits stay zero.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e   kind;
    logic [15:0] tgt;
    logic [15:0] idx;
  } dec_t;

  // word-address map (byte offset >> 2)
  localparam int PEND_W     = 32'h400;
  localparam int EN_W       = 32'h800;
  localparam int EN_STRIDE  = 32'h20;
  localparam int THR_W      = 32'h80000;
  localparam int THR_STRIDE = 32'h400;
endpackage

// File: rtl/pic_apb_dec.sv
module pic_apb_dec
  import pic_pkg::*;
#(
  parameter int ADDR_W  = 26,
  parameter int NUM_SRC = 16,
  parameter int NUM_TGT = 2,
  parameter int N_WORDS = 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);
  logic [31:0] wa;
  logic [1:0]  unused_lsb;

  assign wa         = 32'(addr_i[ADDR_W-1:2]);
  assign unused_lsb = addr_i[1:0];

  always_comb begin
    dec_o = '{kind: RK_NONE, tgt: '0, idx: '0};
    if (wa < 32'(NUM_SRC)) begin
      dec_o.kind = RK_PRIO;
      dec_o.idx  = wa[15:0];
    end else if (wa >= 32'(PEND_W) && wa < 32'(PEND_W + N_WORDS)) begin
      dec_o.kind = RK_PEND;
      dec_o.idx  = 16'(wa - 32'(PEND_W));
    end
    for (int t = 0; t < NUM_TGT; t++) begin
      if (wa >= 32'(EN_W + t * EN_STRIDE) && wa < 32'(EN_W + t * EN_STRIDE + N_WORDS)) begin
        dec_o.kind = RK_EN;
        dec_o.tgt  = 16'(t);
        dec_o.idx  = 16'(wa - 32'(EN_W + t * EN_STRIDE));
      end
      if (wa == 32'(THR_W + t * THR_STRIDE)) begin
        dec_o.kind = RK_THR;
        dec_o.tgt  = 16'(t);
      end
      if (wa == 32'(THR_W + t * THR_STRIDE + 1)) begin
        dec_o.kind = RK_CLAIM;
        dec_o.tgt  = 16'(t);
      end
    end
  end
endmodule

// File: rtl/pic_src_gate.sv
module pic_src_gate (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic src_i,
  input  logic claim_i,
  input  logic done_i,
  output logic pend_o,
  output logic busy_o
);
  // claim wins over completion, completion over new request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_o <= 1'b0;
      busy_o <= 1'b0;
    end else if (claim_i) begin
      pend_o <= 1'b0;
      busy_o <= 1'b1;
    end else if (done_i) begin
      busy_o <= 1'b0;
    end else if (src_i && !busy_o) begin
      pend_o <= 1'b1;
    end
  end
endmodule

// File: rtl/pic_max_sel.sv
module pic_max_sel #(
  parameter int NUM_SRC = 16,
  parameter int PRIO_W  = 2,
  parameter int ID_W    = 4
) (
  input  logic [NUM_SRC-1:0]             elig_i,
  input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_i,
  output logic [ID_W-1:0]                id_o,
  output logic [PRIO_W-1:0]              prio_o
);
  // strict compare: the first (lowest) ID keeps a tie
  always_comb begin
    id_o   = '0;
    prio_o = '0;
    for (int i = 1; i < NUM_SRC; i++) begin
      if (elig_i[i] && prio_i[i] > prio_o) begin
        id_o   = ID_W'(i);
        prio_o = prio_i[i];
      end
    end
  end
endmodule

// File: rtl/pic_top.sv
module pic_top
  import pic_pkg::*;
#(
  parameter int NUM_SRC  = 16,
  parameter int NUM_TGT  = 2,
  parameter int MAX_PRIO = 3,
  parameter int ADDR_W   = 26
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               psel_i,
  input  logic               penable_i,
  input  logic               pwrite_i,
  input  logic [ADDR_W-1:0]  paddr_i,
  input  logic [31:0]        pwdata_i,
  output logic [31:0]        prdata_o,
  output logic               pready_o,
  output logic               pslverr_o,
  output logic [NUM_TGT-1:0] irq_o
);
  localparam int PRIO_W  = $clog2(MAX_PRIO + 1);
  localparam int ID_W    = $clog2(NUM_SRC);
  localparam int N_WORDS = (NUM_SRC + 31) / 32;

  logic [NUM_SRC-1:0][PRIO_W-1:0] prio_q;
  logic [NUM_TGT-1:0][NUM_SRC-1:0] en_q;
  logic [NUM_TGT-1:0][PRIO_W-1:0] thr_q;
  logic [NUM_SRC-1:0]             pend_q, busy_q;
  logic [NUM_SRC-1:0]             claim_src, done_src;
  logic [NUM_TGT-1:0][ID_W-1:0]   sel_id;
  logic [NUM_TGT-1:0][PRIO_W-1:0] sel_prio;
  dec_t                           dec;
  logic                           acc, wr, rd;
  logic [31:0]                    rdata;
  logic                           unused_src0;

  assign acc         = psel_i & penable_i;
  assign wr          = acc & pwrite_i;
  assign rd          = acc & ~pwrite_i;
  assign unused_src0 = src_i[0];

  pic_apb_dec #(
    .ADDR_W (ADDR_W),
    .NUM_SRC(NUM_SRC),
    .NUM_TGT(NUM_TGT),
    .N_WORDS(N_WORDS)
  ) u_dec (
    .addr_i(paddr_i),
    .dec_o (dec)
  );

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    if (s == 0) begin : g_none
      assign pend_q[s] = 1'b0;
      assign busy_q[s] = 1'b0;
    end else begin : g_gate
      pic_src_gate u_gate (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .src_i  (src_i[s]),
        .claim_i(claim_src[s]),
        .done_i (done_src[s]),
        .pend_o (pend_q[s]),
        .busy_o (busy_q[s])
      );
    end
  end

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_tgt
    pic_max_sel #(
      .NUM_SRC(NUM_SRC),
      .PRIO_W (PRIO_W),
      .ID_W   (ID_W)
    ) u_sel (
      .elig_i(pend_q & en_q[t]),
      .prio_i(prio_q),
      .id_o  (sel_id[t]),
      .prio_o(sel_prio[t])
    );
    assign irq_o[t] = sel_prio[t] > thr_q[t];
  end

  // claim and completion routing
  always_comb begin
    claim_src = '0;
    done_src  = '0;
    for (int t = 0; t < NUM_TGT; t++) begin
      if (dec.kind == RK_CLAIM && dec.tgt == 16'(t)) begin
        for (int s = 1; s < NUM_SRC; s++) begin
          if (rd && sel_id[t] == ID_W'(s)) claim_src[s] = 1'b1;
          if (wr && pwdata_i == 32'(s) && en_q[t][s]) done_src[s] = 1'b1;
        end
      end
    end
  end

  // configuration registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prio_q <= '0;
      en_q   <= '0;
      thr_q  <= '0;
    end else if (wr) begin
      case (dec.kind)
        RK_PRIO: begin
          for (int s = 1; s < NUM_SRC; s++)
            if (dec.idx == 16'(s)) prio_q[s] <= pwdata_i[PRIO_W-1:0];
        end
        RK_EN: begin
          for (int t = 0; t < NUM_TGT; t++)
            if (dec.tgt == 16'(t))
              for (int s = 1; s < NUM_SRC; s++)
                if (int'(dec.idx) == s / 32) en_q[t][s] <= pwdata_i[s % 32];
        end
        RK_THR: begin
          for (int t = 0; t < NUM_TGT; t++)
            if (dec.tgt == 16'(t)) thr_q[t] <= pwdata_i[PRIO_W-1:0];
        end
        default: ;
      endcase
    end
  end

  // read mux
  always_comb begin
    rdata = '0;
    case (dec.kind)
      RK_PRIO: begin
        for (int s = 0; s < NUM_SRC; s++)
          if (dec.idx == 16'(s)) rdata[PRIO_W-1:0] = prio_q[s];
      end
      RK_PEND: begin
        for (int s = 1; s < NUM_SRC; s++)
          if (int'(dec.idx) == s / 32) rdata[s % 32] = pend_q[s];
      end
      RK_EN: begin
        for (int t = 0; t < NUM_TGT; t++)
          if (dec.tgt == 16'(t))
            for (int s = 1; s < NUM_SRC; s++)
              if (int'(dec.idx) == s / 32) rdata[s % 32] = en_q[t][s];
      end
      RK_THR: begin
        for (int t = 0; t < NUM_TGT; t++)
          if (dec.tgt == 16'(t)) rdata[PRIO_W-1:0] = thr_q[t];
      end
      RK_CLAIM: begin
        for (int t = 0; t < NUM_TGT; t++)
          if (dec.tgt == 16'(t)) rdata[ID_W-1:0] = sel_id[t];
      end
      default: ;
    endcase
  end

  assign prdata_o  = rd ? rdata : '0;
  assign pready_o  = acc;
  assign pslverr_o = acc & (dec.kind == RK_NONE);
endmodule

// File: rtl/pic_chk.sv
module pic_chk #(
  parameter int NUM_SRC = 16,
  parameter int NUM_TGT = 2,
  parameter int ID_W    = 4,
  parameter int ADDR_W  = 26
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         psel_i,
  input logic                         penable_i,
  input logic                         pwrite_i,
  input logic [ADDR_W-1:0]            paddr_i,
  input logic [31:0]                  prdata_o,
  input logic                         pready_o,
  input logic                         pslverr_o,
  input logic [NUM_TGT-1:0]           irq_o,
  input logic [NUM_SRC-1:0]           pend_q,
  input logic [NUM_SRC-1:0]           busy_q,
  input logic [NUM_TGT-1:0][ID_W-1:0] sel_id
);
  logic        rd, claim_rd, pend_rd;
  logic [31:0] pg;
  logic [1:0]  unused_lsb;

  assign unused_lsb = paddr_i[1:0];
  assign rd         = psel_i && penable_i && !pwrite_i;
  assign pg         = 32'(paddr_i[ADDR_W-1:12]);
  assign claim_rd   = rd && paddr_i[11:2] == 10'd1 && pg >= 32'h200 && pg < 32'h200 + 32'(NUM_TGT);
  assign pend_rd    = rd && 32'(paddr_i[ADDR_W-1:2]) == 32'h400;

  AST_ERR_IN_ACCESS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> psel_i && penable_i && pready_o); // R10
  AST_NO_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    psel_i && penable_i |-> pready_o); // R12
  AST_PEND_BUSY_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q & busy_q) == '0); // R7
  AST_CLAIM_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    claim_rd && prdata_o != 32'd0 |=> !pend_q[$past(prdata_o[ID_W-1:0])]); // R6
  AST_PEND_BIT0_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_rd |-> !prdata_o[0]); // R2

  for (genvar t = 0; t < NUM_TGT; t++) begin : g_t
    AST_IRQ_HAS_ID: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[t] |-> sel_id[t] != '0); // R9
  end
endmodule

bind pic_top pic_chk #(
  .NUM_SRC(NUM_SRC),
  .NUM_TGT(NUM_TGT),
  .ID_W   (ID_W),
  .ADDR_W (ADDR_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .psel_i   (psel_i),
  .penable_i(penable_i),
  .pwrite_i (pwrite_i),
  .paddr_i  (paddr_i),
  .prdata_o (prdata_o),
  .pready_o (pready_o),
  .pslverr_o(pslverr_o),
  .irq_o    (irq_o),
  .pend_q   (pend_q),
  .busy_q   (busy_q),
  .sel_id   (sel_id)
);

// File: tb/pic_top_tb.sv
module pic_top_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NS = 16;
  localparam int NT = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] src = '0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [25:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic        pready, pslverr;
  logic [1:0]  irq;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  bit [1:0] m_prio[NS];
  bit       m_en[NT][NS];
  bit [1:0] m_thr[NT];
  bit       m_pend[NS];
  bit       m_busy[NS];

  always #(CLK_PERIOD / 2) clk = ~clk;

  pic_top u_dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src),
    .psel_i(psel), .penable_i(penable), .pwrite_i(pwrite),
    .paddr_i(paddr), .pwdata_i(pwdata), .prdata_o(prdata),
    .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  // 0 none, 1 prio, 2 pend, 3 en, 4 thr, 5 claim
  function automatic int dec(input logic [25:0] a, output int t, output int idx);
    int w;
    w = int'(a >> 2); t = 0; idx = 0;
    if (w < NS) begin idx = w; return 1; end
    if (w == 'h400) return 2;
    for (int k = 0; k < NT; k++) begin
      t = k;
      if (w == 'h800 + k * 'h20) return 3;
      if (w == 'h80000 + k * 'h400) return 4;
      if (w == 'h80001 + k * 'h400) return 5;
    end
    t = 0;
    return 0;
  endfunction

  function automatic int best(input int t);
    int id, bp;
    id = 0; bp = 0;
    for (int s = 1; s < NS; s++)
      if (m_pend[s] && m_en[t][s] && int'(m_prio[s]) > bp) begin id = s; bp = int'(m_prio[s]); end
    return id;
  endfunction

  function automatic int best_prio(input int t);
    int b;
    b = best(t);
    return (b == 0) ? 0 : int'(m_prio[b]);
  endfunction

  function automatic logic [31:0] exp_rd(input logic [25:0] a);
    int t, idx, k;
    logic [31:0] r;
    r = '0;
    k = dec(a, t, idx);
    case (k)
      1: r[1:0] = m_prio[idx];
      2: for (int s = 1; s < NS; s++) r[s] = m_pend[s];
      3: for (int s = 1; s < NS; s++) r[s] = m_en[t][s];
      4: r[1:0] = m_thr[t];
      5: r = 32'(best(t));
      default: r = '0;
    endcase
    return r;
  endfunction

  function automatic string tag_of(input logic [25:0] a);
    int t, idx;
    case (dec(a, t, idx))
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      default: return "R10";
    endcase
  endfunction

  // reference model, one step per clock edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < NS; s++) begin
        m_prio[s] = '0; m_pend[s] = 1'b0; m_busy[s] = 1'b0;
        for (int t = 0; t < NT; t++) m_en[t][s] = 1'b0;
      end
      for (int t = 0; t < NT; t++) m_thr[t] = '0;
    end else begin
      int k, t, idx, clm, cmp;
      clm = 0; cmp = 0;
      if (psel && penable) begin
        k = dec(paddr, t, idx);
        if (pwrite) begin
          case (k)
            1: if (idx != 0) m_prio[idx] = pwdata[1:0];
            3: for (int s = 1; s < NS; s++) m_en[t][s] = pwdata[s];
            4: m_thr[t] = pwdata[1:0];
            5: if (pwdata != 0 && pwdata < NS && m_en[t][pwdata[3:0]]) cmp = int'(pwdata);
            default: ;
          endcase
        end else if (k == 5) begin
          clm = best(t);
        end
      end
      for (int s = 1; s < NS; s++) begin
        if (s == clm) begin m_pend[s] = 1'b0; m_busy[s] = 1'b1; end
        else if (s == cmp) m_busy[s] = 1'b0;
        else if (src[s] && !m_busy[s]) m_pend[s] = 1'b1;
      end
    end
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // irq outputs compared each cycle
  always @(negedge clk) begin
    #2;
    if (rst_n && !done)
      for (int t = 0; t < NT; t++)
        check(irq[t] == (best_prio(t) > int'(m_thr[t])), "R9", 32'(irq[t]),
              32'(best_prio(t) > int'(m_thr[t])));
  end

  task automatic apb(input bit w, input logic [25:0] a, input logic [31:0] d, input string tag = "");
    int t, idx;
    bit err;
    logic [31:0] e;
    string tg;
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = w; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1'b1;
    #1;
    tg  = (tag == "") ? tag_of(a) : tag;
    err = (dec(a, t, idx) == 0);
    check(pready === 1'b1, "R12", 32'(pready), 32'd1);
    check(pslverr === err, "R10", 32'(pslverr), 32'(err));
    if (!w) begin
      e = exp_rd(a);
      check(prdata === e, tg, prdata, e);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    psel = 1'b0; penable = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [25:0] a_prio(input int id); return 26'(4 * id); endfunction
  function automatic logic [25:0] a_en(input int t); return 26'('h2000 + 'h80 * t); endfunction
  function automatic logic [25:0] a_thr(input int t); return 26'('h200000 + 'h1000 * t); endfunction
  function automatic logic [25:0] a_clm(input int t); return 26'('h200004 + 'h1000 * t); endfunction
  localparam logic [25:0] A_PEND = 26'h1000;

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11: reset state
    check(irq === 2'b00, "R11", 32'(irq), 32'd0);
    for (int s = 0; s < NS; s++) apb(0, a_prio(s), 0, "R11");
    apb(0, A_PEND, 0, "R11");
    for (int t = 0; t < NT; t++) begin
      apb(0, a_en(t), 0, "R11");
      apb(0, a_thr(t), 0, "R11");
      apb(0, a_clm(t), 0, "R11");
    end

    // R1: reserved bits, ID 0 entry
    apb(1, a_prio(5), 32'hFFFF_FFFF);
    apb(0, a_prio(5), 0, "R1");
    apb(1, a_prio(0), 32'h3);
    apb(0, a_prio(0), 0, "R1");
    // R3: bit 0 hardwired
    apb(1, a_en(0), 32'hFFFF_FFFF);
    apb(0, a_en(0), 0, "R3");
    // R4
    apb(1, a_thr(1), 32'hFFFF_FFFE);
    apb(0, a_thr(1), 0, "R4");
    apb(1, a_thr(1), 0);

    // R5 tie-break: IDs 3 and 7 at equal priority
    apb(1, a_en(0), 32'h0000_0088);
    apb(1, a_prio(3), 2);
    apb(1, a_prio(7), 2);
    apb(1, a_prio(5), 0);
    src = 16'h0088;
    idle(2);
    apb(0, A_PEND, 0, "R2");
    apb(0, a_clm(0), 0, "R5");
    apb(0, A_PEND, 0, "R6");
    apb(0, a_clm(0), 0, "R5");
    // R7: inputs still high, both held off while in service
    idle(3);
    apb(0, A_PEND, 0, "R7");
    apb(1, a_clm(0), 3);
    apb(0, A_PEND, 0, "R7");
    // R8: ID 7 not enabled for target 1, completion dropped
    apb(1, a_clm(1), 7);
    idle(2);
    apb(0, A_PEND, 0, "R8");
    apb(1, a_clm(0), 7);
    apb(0, A_PEND, 0, "R8");
    // R2: write to pending ignored
    apb(1, A_PEND, 32'h0);
    apb(0, A_PEND, 0, "R2");
    // R9 threshold mask, R5 claim ignores threshold
    apb(1, a_thr(0), 2);
    idle(2);
    apb(0, a_clm(0), 0, "R5");
    apb(1, a_thr(0), 0);
    // R10: unmapped neighbours
    apb(0, 26'h40, 0, "R10");
    apb(0, 26'h1004, 0, "R10");
    apb(0, 26'h2004, 0, "R10");
    apb(0, 26'h2100, 0, "R10");
    apb(0, 26'h200008, 0, "R10");
    apb(0, 26'h202000, 0, "R10");
    apb(1, 26'h3FF_FFFC, 32'hFFFF_FFFF);
    apb(0, 26'h3FF_FFFC, 0, "R10");
    src = '0;

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op, t;
      t  = int'($urandom_range(0, NT - 1));
      op = int'($urandom_range(0, 99));
      if ($urandom_range(0, 7) == 0) src = 16'($urandom) & 16'hFFFE;
      if (op < 30) apb(0, a_clm(t), 0);
      else if (op < 50) apb(1, a_clm(t), 32'($urandom_range(0, NS)));
      else if (op < 58) apb(1, a_prio(int'($urandom_range(0, NS - 1))), $urandom);
      else if (op < 64) apb(1, a_en(t), $urandom);
      else if (op < 68) apb(1, a_thr(t), 32'($urandom_range(0, 3)));
      else if (op < 90) begin
        case ($urandom_range(0, 3))
          0: apb(0, A_PEND, 0);
          1: apb(0, a_en(t), 0);
          2: apb(0, a_thr(t), 0);
          default: apb(0, a_prio(int'($urandom_range(0, NS - 1))), 0);
        endcase
      end else apb(bit'($urandom_range(0, 1)), 26'($urandom) & 26'h3FF_FFFC, $urandom);
      if ($urandom_range(0, 9) == 0) idle(int'($urandom_range(0, 3)));
    end
    idle(2);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule